// File: doc/BRIEF.md
# Cross-Processor Doorbell Sync Register Pair

This block links two processors, called side A and side B, through a pair of 32-bit sync registers. Each side has its own register on its own bus port. A side posts an 8-bit message byte into its register, and the peer sees that byte in the low byte of its own register. Each side also holds an interrupt-enable bit. Either side can ring a doorbell toward either processor by writing a trigger bit. The doorbell is delivered only if the targeted processor has its enable set.

Each side has a small interrupt state machine with three states: `ST_IDLE`, `ST_RAISE` and `ST_PENDING`. A delivered request takes the machine from any state to `ST_RAISE` (transition *raise*). From `ST_RAISE`, the next cycle moves it to `ST_PENDING` (transition *settle*) unless a clear arrives. A clear takes `ST_RAISE` or `ST_PENDING` back to `ST_IDLE` (transition *clear*). A clear is either the dedicated acknowledge input or a write by the owning side to its top byte with both trigger bits 0. When a raise and a clear happen in the same cycle, the raise wins. A parameter selects, per side, whether the interrupt output is a level (high in `ST_RAISE` and `ST_PENDING`) or a one-cycle pulse (high in `ST_RAISE` only).

Register layout, identical on both sides:

| Bits | Access | Meaning |
|---|---|---|
| 31 | read/write | enable of this side's doorbell interrupt |
| 30 | write only, reads 0 | trigger: request an interrupt on side A |
| 29 | write only, reads 0 | trigger: request an interrupt on side B |
| 28:16 | none, reads 0 | reserved |
| 15:8 | read/write | outgoing message byte |
| 7:0 | read only | the peer's outgoing message byte |

Writes use byte-lane strobes. Strobe bit n covers data bits 8n+7 down to 8n.

Top module: `sync_pair`

## Requirements
- R1: After reset, both read-data outputs are 0 and both interrupt outputs are low.
- R2: A write with strobe bit 1 set loads data bits 15:8 into this side's outgoing byte. The byte reads back on bits 15:8 from the next cycle and is held while no such write occurs.
- R3: Bits 7:0 of each side's read data equal the peer's outgoing byte from the cycle after the peer's write. Writes to lane 0 change nothing.
- R4: A write with strobe bit 3 set loads data bit 31 into this side's enable, which reads back on bit 31.
- R5: A lane-3 write from either side with bit 29 set requests side B's interrupt, and one with bit 30 set requests side A's interrupt. Bits 29 and 30 always read as 0.
- R6: A request whose target enable was 0 before the write's clock edge has no effect: the target interrupt stays low and nothing becomes pending. This holds even when the same write sets that enable.
- R7: A delivered request raises the target interrupt in the cycle after the write. A level-mode side stays high until cleared. A pulse-mode side is high for exactly one cycle.
- R8: A pending interrupt clears when the owning side asserts its acknowledge, or when it writes lane 3 with bits 29 and 30 both 0. A request in the same cycle overrides the clear.
- R9: Bits 28:16 read as 0, and writes to lane 2 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| a_wr | input | 1 | side A write strobe |
| a_be | input | 4 | side A byte-lane enables |
| a_wdata | input | 32 | side A write data |
| a_rdata | output | 32 | side A register read value |
| a_ack | input | 1 | side A interrupt acknowledge |
| a_irq | output | 1 | side A doorbell interrupt |
| b_wr | input | 1 | side B write strobe |
| b_be | input | 4 | side B byte-lane enables |
| b_wdata | input | 32 | side B write data |
| b_rdata | output | 32 | side B register read value |
| b_ack | input | 1 | side B interrupt acknowledge |
| b_irq | output | 1 | side B doorbell interrupt |

## Verification
The bench builds the block with side A in level mode (`A_PULSE=0`) and side B in pulse mode (`B_PULSE=1`). Both interrupt output variants are therefore compared against the reference model in one run. This reaches the one-cycle-high pulse behaviour and the held level behaviour under the same trigger traffic. It also reaches the case where a trigger and a clear of the level side land in the same cycle.

// File: rtl/sync_pkg.sv
package sync_pkg;
    localparam int REG_W      = 32;
    localparam int LANE_W     = 8;
    localparam int LANES      = REG_W / LANE_W;
    localparam int MSG_LANE   = 1;
    localparam int CTRL_LANE  = 3;
    localparam int MSG_LSB    = MSG_LANE * LANE_W;
    localparam int EN_BIT     = 31;
    localparam int TRIG_A_BIT = 30;
    localparam int TRIG_B_BIT = 29;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RAISE   = 2'd1,
        ST_PENDING = 2'd2
    } irq_state_t;
endpackage

// File: rtl/sync_side_reg.sv
module sync_side_reg
    import sync_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [LANES-1:0]    be,
    input  logic [REG_W-1:0]    wdata,
    output logic [LANE_W-1:0]   msg,
    output logic                en,
    output logic                req_a,
    output logic                req_b,
    output logic                clr_wr
);
    logic msg_we;
    logic ctrl_we;

    always_comb begin
        msg_we  = wr && be[MSG_LANE];
        ctrl_we = wr && be[CTRL_LANE];
        req_a   = ctrl_we && wdata[TRIG_A_BIT];
        req_b   = ctrl_we && wdata[TRIG_B_BIT];
        clr_wr  = ctrl_we && !wdata[TRIG_A_BIT] && !wdata[TRIG_B_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg <= '0;
            en  <= 1'b0;
        end else begin
            if (msg_we) begin
                msg <= wdata[MSG_LSB +: LANE_W];
            end
            if (ctrl_we) begin
                en <= wdata[EN_BIT];
            end
        end
    end

    // R2: message byte loads from lane 1
    a_r2_msg_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && be[MSG_LANE]) |=> (msg == $past(wdata[MSG_LSB +: LANE_W])));
    // R2: message byte holds without a lane-1 write
    a_r2_msg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && be[MSG_LANE]) |=> $stable(msg));
    // R4: enable holds without a lane-3 write
    a_r4_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && be[CTRL_LANE]) |=> $stable(en));
endmodule

// File: rtl/sync_irq_fsm.sv
module sync_irq_fsm
    import sync_pkg::*;
#(
    parameter bit PULSE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic clr,
    output logic irq
);
    irq_state_t state_q;
    irq_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (raise) state_d = ST_RAISE;
            end
            ST_RAISE: begin
                if (raise)    state_d = ST_RAISE;
                else if (clr) state_d = ST_IDLE;
                else          state_d = ST_PENDING;
            end
            ST_PENDING: begin
                if (raise)    state_d = ST_RAISE;
                else if (clr) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    generate
        if (PULSE) begin : g_pulse
            always_comb irq = (state_q == ST_RAISE);
        end else begin : g_level
            always_comb irq = (state_q == ST_RAISE) || (state_q == ST_PENDING);
        end
    endgenerate

    // R7: the interrupt only rises after a delivered request
    a_r7_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(raise));
    // R8: a clear without a request empties the machine
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !raise) |=> (state_q == ST_IDLE));
    // R7: a request always lands in the raise state
    a_r7_raise: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> (state_q == ST_RAISE));
endmodule

// File: rtl/sync_pair.sv
module sync_pair
    import sync_pkg::*;
#(
    parameter bit A_PULSE = 1'b0,
    parameter bit B_PULSE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr,
    input  logic [3:0]        a_be,
    input  logic [31:0]       a_wdata,
    output logic [31:0]       a_rdata,
    input  logic              a_ack,
    output logic              a_irq,
    input  logic              b_wr,
    input  logic [3:0]        b_be,
    input  logic [31:0]       b_wdata,
    output logic [31:0]       b_rdata,
    input  logic              b_ack,
    output logic              b_irq
);
    logic [LANE_W-1:0] a_msg, b_msg;
    logic a_en, b_en;
    logic a_req_a, a_req_b, a_clr_wr;
    logic b_req_a, b_req_b, b_clr_wr;
    logic raise_a, raise_b;

    sync_side_reg u_reg_a (
        .clk(clk), .rst_n(rst_n), .wr(a_wr), .be(a_be), .wdata(a_wdata),
        .msg(a_msg), .en(a_en), .req_a(a_req_a), .req_b(a_req_b), .clr_wr(a_clr_wr)
    );

    sync_side_reg u_reg_b (
        .clk(clk), .rst_n(rst_n), .wr(b_wr), .be(b_be), .wdata(b_wdata),
        .msg(b_msg), .en(b_en), .req_a(b_req_a), .req_b(b_req_b), .clr_wr(b_clr_wr)
    );

    always_comb begin
        raise_a = (a_req_a || b_req_a) && a_en;
        raise_b = (a_req_b || b_req_b) && b_en;
    end

    sync_irq_fsm #(.PULSE(A_PULSE)) u_irq_a (
        .clk(clk), .rst_n(rst_n), .raise(raise_a), .clr(a_ack || a_clr_wr), .irq(a_irq)
    );

    sync_irq_fsm #(.PULSE(B_PULSE)) u_irq_b (
        .clk(clk), .rst_n(rst_n), .raise(raise_b), .clr(b_ack || b_clr_wr), .irq(b_irq)
    );

    always_comb begin
        a_rdata = '0;
        a_rdata[EN_BIT] = a_en;
        a_rdata[MSG_LSB +: LANE_W] = a_msg;
        a_rdata[0 +: LANE_W] = b_msg;
        b_rdata = '0;
        b_rdata[EN_BIT] = b_en;
        b_rdata[MSG_LSB +: LANE_W] = b_msg;
        b_rdata[0 +: LANE_W] = a_msg;
    end

    // R3: side A's posted byte shows up on side B's low byte
    a_r3_cross_ab: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && a_be[MSG_LANE]) |=> (b_rdata[7:0] == $past(a_wdata[15:8])));
    // R3: side B's posted byte shows up on side A's low byte
    a_r3_cross_ba: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && b_be[MSG_LANE]) |=> (a_rdata[7:0] == $past(b_wdata[15:8])));
    // R6: with side B disabled and no request, side B's interrupt cannot rise
    a_r6_gate_b: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_en && !b_irq) |=> !b_irq);
endmodule

// File: tb/test_sync_pair.sv
`timescale 1ns/1ps
module test_sync_pair;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_wr = 0, b_wr = 0, a_ack = 0, b_ack = 0;
    logic [3:0] a_be = 0, b_be = 0;
    logic [31:0] a_wdata = 0, b_wdata = 0;
    logic [31:0] a_rdata, b_rdata;
    logic a_irq, b_irq;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // reference model state: 0 idle, 1 just raised, 2 pending
    int m_sa = 0, m_sb = 0;
    logic [7:0] m_ma = 0, m_mb = 0;
    logic m_ea = 0, m_eb = 0;

    always #4 clk = ~clk;

    sync_pair #(.A_PULSE(1'b0), .B_PULSE(1'b1)) i_sync_pair (
        .clk(clk), .rst_n(rst_n),
        .a_wr(a_wr), .a_be(a_be), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_ack(a_ack), .a_irq(a_irq),
        .b_wr(b_wr), .b_be(b_be), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_ack(b_ack), .b_irq(b_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int next_st(int st, bit raise, bit clr);
        if (raise) return 1;
        if (st != 0 && clr) return 0;
        if (st == 1) return 2;
        return st;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sa = 0; m_sb = 0; m_ma = 0; m_mb = 0; m_ea = 0; m_eb = 0;
        end else begin
            bit ca, cb, ra, rb;
            ca = a_wr && a_be[3];
            cb = b_wr && b_be[3];
            ra = ((ca && a_wdata[30]) || (cb && b_wdata[30])) && m_ea;
            rb = ((ca && a_wdata[29]) || (cb && b_wdata[29])) && m_eb;
            m_sa = next_st(m_sa, ra, a_ack || (ca && !a_wdata[30] && !a_wdata[29]));
            m_sb = next_st(m_sb, rb, b_ack || (cb && !b_wdata[30] && !b_wdata[29]));
            if (a_wr && a_be[1]) m_ma = a_wdata[15:8];
            if (b_wr && b_be[1]) m_mb = b_wdata[15:8];
            if (ca) m_ea = a_wdata[31];
            if (cb) m_eb = b_wdata[31];
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", {24'b0, a_rdata[15:8]}, {24'b0, m_ma});
            chk("R2", {24'b0, b_rdata[15:8]}, {24'b0, m_mb});
            chk("R3", {24'b0, a_rdata[7:0]}, {24'b0, m_mb});
            chk("R3", {24'b0, b_rdata[7:0]}, {24'b0, m_ma});
            chk("R4", {31'b0, a_rdata[31]}, {31'b0, m_ea});
            chk("R4", {31'b0, b_rdata[31]}, {31'b0, m_eb});
            chk("R9", {3'b0, a_rdata[28:16], 16'b0}, 32'b0);
            chk("R5", {30'b0, a_rdata[30:29]}, 32'b0);
            chk("R5", {30'b0, b_rdata[30:29]}, 32'b0);
            chk(cur_req, {31'b0, a_irq}, {31'b0, m_sa != 0});
            chk(cur_req, {31'b0, b_irq}, {31'b0, m_sb == 1});
        end
    end

    task automatic wa(input logic [3:0] be, input logic [31:0] d, input logic ack_a = 0, input logic ack_b = 0);
        a_wr = 1; a_be = be; a_wdata = d; a_ack = ack_a; b_ack = ack_b;
        @(negedge clk);
        a_wr = 0; a_be = 0; a_wdata = 0; a_ack = 0; b_ack = 0;
    endtask

    task automatic wb(input logic [3:0] be, input logic [31:0] d, input logic ack_a = 0, input logic ack_b = 0);
        b_wr = 1; b_be = be; b_wdata = d; a_ack = ack_a; b_ack = ack_b;
        @(negedge clk);
        b_wr = 0; b_be = 0; b_wdata = 0; a_ack = 0; b_ack = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        chk("R1", a_rdata, 32'h0); chk("R1", b_rdata, 32'h0);
        chk("R1", {31'b0, a_irq | b_irq}, 32'h0);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R2";
        wa(4'b0010, 32'h0000_5A00);
        chk("R2", a_rdata, 32'h0000_5A00);
        cur_req = "R3";
        wb(4'b0010, 32'h0000_C300);
        chk("R3", a_rdata, 32'h0000_5AC3);
        wa(4'b0001, 32'hFFFF_FFFF);
        chk("R3", a_rdata, 32'h0000_5AC3);
        cur_req = "R9";
        wa(4'b0100, 32'hFFFF_FFFF);
        chk("R9", a_rdata, 32'h0000_5AC3);

        cur_req = "R6";
        wa(4'b1000, 32'h2000_0000);
        idle(2);
        chk("R6", {31'b0, b_irq}, 32'h0);
        cur_req = "R4";
        wb(4'b1000, 32'h8000_0000);
        chk("R4", b_rdata, 32'h8000_C35A);

        cur_req = "R7";
        wa(4'b1000, 32'h2000_0000);
        chk("R7", {31'b0, b_irq}, 32'h1);
        idle(1);
        chk("R7", {31'b0, b_irq}, 32'h0);
        wb(4'b0000, 32'h0, 1'b0, 1'b1);

        wa(4'b1000, 32'h8000_0000);
        wb(4'b1000, 32'hC000_0000);
        chk("R5", {31'b0, a_irq}, 32'h1);
        idle(3);
        chk("R7", {31'b0, a_irq}, 32'h1);
        cur_req = "R8";
        wa(4'b1000, 32'h8000_0000);
        chk("R8", {31'b0, a_irq}, 32'h0);

        cur_req = "R5";
        wa(4'b1000, 32'hC000_0000);
        chk("R5", {31'b0, a_irq}, 32'h1);
        cur_req = "R8";
        wb(4'b1000, 32'hC000_0000, 1'b1, 1'b0);
        chk("R8", {31'b0, a_irq}, 32'h1);
        wa(4'b0000, 32'h0, 1'b1, 1'b0);
        chk("R8", {31'b0, a_irq}, 32'h0);

        cur_req = "R6";
        wb(4'b1000, 32'h0000_0000);
        wb(4'b1000, 32'hA000_0000);
        chk("R6", {31'b0, b_irq}, 32'h0);
        idle(1);
        chk("R6", {31'b0, b_irq}, 32'h0);

        cur_req = "R9";
        wa(4'b1111, 32'hFFFF_FFFF);
        chk("R9", a_rdata, 32'h8000_FFC3);
        chk("R7", {31'b0, b_irq}, 32'h1);
        idle(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule